// File: doc/BRIEF.md
# Clock-Gating Power Management Controller

This block decides which clocks in a subsystem are allowed to run. Each peripheral owns one enable bit. Software turns bits on through a write-one-to-set strobe and off through a write-one-to-clear strobe. The current enables are read back on a status port. Every enable drives a glitch-free gate cell, which samples its enable while the clock is low and passes the free-running clock only when the enable is high. A disabled peripheral keeps all of its register and memory contents, so it carries on from the same point when its clock returns.

The processor clock is handled by a small state machine with three states:
- `CPU_RUN` (code 0): the clock runs.
- `CPU_STOP_PEND` (code 1): a stop has been asked for and the controller is waiting for the instruction in progress to finish.
- `CPU_STOPPED` (code 2): the clock is gated.

The transitions are:
- `RUN→STOP_PEND` on an idle request when no wake is present.
- `STOP_PEND→STOPPED` on instruction-complete when no wake is present.
- `STOP_PEND→RUN` (cancel) on a wake.
- `STOPPED→RUN` (wake-up) on any interrupt that is both pending and enabled.

All other cases hold the current state. A hardware reset always returns the processor clock to running.

Top module: `pwr_clk_gate_ctrl`

## Requirements
- R1: After reset every peripheral enable is 0, `cpu_state` is 0 (run) and `cpu_running` is 1.
- R2: A cycle with `set_we` high sets every enable bit where `set_mask` is 1, from the next cycle on. All other bits keep their value.
- R3: A cycle with `clr_we` high clears every enable bit where `clr_mask` is 1, from the next cycle on, with no handshake. All other bits keep their value.
- R4: When the same bit is marked in `set_mask` and `clr_mask` in the same cycle, the set wins and the bit ends up at 1.
- R5: An idle request moves the state from run to 1 (stop pending). The processor clock keeps toggling until `cpu_insn_done` is sampled. The state then becomes 2 (stopped), `cpu_running` falls, and `cpu_gclk` stays low.
- R6: In the stopped state, a pending interrupt whose enable bit is 0 has no effect. Any pending interrupt whose enable bit is 1 returns the state to 0 (run) on the next cycle.
- R7: An enabled pending interrupt in the stop-pending state cancels the stop, even when `cpu_insn_done` is high in the same cycle. The state returns to 0.
- R8: A peripheral gated clock toggles with `clk` while its enable is 1 and stays low while its enable is 0.
- R9: Peripheral set and clear writes still take effect while the processor clock is stopped. Stopping and restarting the processor clock does not change any peripheral enable.
- R10: An idle request in the stop-pending or stopped state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_we | input | 1 | Write-one-to-set strobe |
| set_mask | input | N_PERIPH | Bits to enable |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | N_PERIPH | Bits to disable |
| cpu_idle_req | input | 1 | Request to stop the processor clock |
| cpu_insn_done | input | 1 | Instruction in progress has completed |
| irq_pending | input | N_IRQ | Pending interrupt lines |
| irq_enable | input | N_IRQ | Interrupt enable mask used for wake-up |
| periph_gclk | output | N_PERIPH | Gated peripheral clocks |
| cpu_gclk | output | 1 | Gated processor clock |
| periph_status | output | N_PERIPH | Readback of the peripheral enables |
| cpu_state | output | 2 | Processor clock state: 0 run, 1 stop pending, 2 stopped |
| cpu_running | output | 1 | Processor clock enable readback |

## Verification
Two events can land on the same edge: the cancel of a pending stop by an enabled interrupt, and the instruction-complete handshake that would finish the stop. The bench raises `cpu_insn_done` and an enabled `irq_pending` in one cycle while in the stop-pending state. It expects the state to read 0 afterwards and the processor clock to keep toggling. The same approach covers set and clear marking the same enable bit in one write cycle, where the bit must read 1.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
    typedef enum logic [1:0] {
        CPU_RUN       = 2'd0,
        CPU_STOP_PEND = 2'd1,
        CPU_STOPPED   = 2'd2
    } cpu_state_e;
endpackage

// File: rtl/pcm_enable_regs.sv
module pcm_enable_regs #(
    parameter int N_PERIPH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_we,
    input  logic [N_PERIPH-1:0] set_mask,
    input  logic                clr_we,
    input  logic [N_PERIPH-1:0] clr_mask,
    output logic [N_PERIPH-1:0] en_q
);
    logic [N_PERIPH-1:0] set_v;
    logic [N_PERIPH-1:0] clr_v;
    logic [N_PERIPH-1:0] en_d;

    always_comb begin
        set_v = set_we ? set_mask : '0;
        clr_v = clr_we ? clr_mask : '0;
        // set has priority over clear on the same bit
        en_d  = (en_q & ~clr_v) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((en_q & $past(set_mask)) == $past(set_mask)));

    a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((en_q & $past(clr_mask)) == '0));

    a_r2_unmarked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(en_q));
endmodule

// File: rtl/pcm_cpu_fsm.sv
module pcm_cpu_fsm
    import pcm_pkg::*;
#(
    parameter int N_IRQ = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle_req,
    input  logic             insn_done,
    input  logic [N_IRQ-1:0] irq_pending,
    input  logic [N_IRQ-1:0] irq_enable,
    output cpu_state_e       state_q,
    output logic             cpu_clk_en
);
    cpu_state_e state_d;
    logic       wake;

    assign wake = |(irq_pending & irq_enable);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CPU_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CPU_RUN: begin
                if (idle_req && !wake) state_d = CPU_STOP_PEND;
            end
            CPU_STOP_PEND: begin
                if (wake)           state_d = CPU_RUN;
                else if (insn_done) state_d = CPU_STOPPED;
            end
            CPU_STOPPED: begin
                if (wake) state_d = CPU_RUN;
            end
            default: state_d = CPU_RUN;
        endcase
    end

    always_comb begin
        cpu_clk_en = (state_q != CPU_STOPPED);
    end

    a_r5_wait_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CPU_STOP_PEND && !insn_done && !wake) |=> (state_q == CPU_STOP_PEND));

    a_r6_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CPU_STOPPED && wake) |=> (state_q == CPU_RUN));

    a_r7_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CPU_STOP_PEND && wake) |=> (state_q == CPU_RUN));

    a_r10_stay_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CPU_STOPPED && !wake) |=> (state_q == CPU_STOPPED));
endmodule

// File: rtl/pcm_clk_gate.sv
module pcm_clk_gate (
    input  logic clk,
    input  logic en,
    output logic gclk
);
    logic en_lat;

    // enable captured only while the clock is low: no partial pulses
    always_latch begin
        if (!clk) en_lat <= en;
    end

    assign gclk = clk & en_lat;
endmodule

// File: rtl/pwr_clk_gate_ctrl.sv
module pwr_clk_gate_ctrl
    import pcm_pkg::*;
#(
    parameter int N_PERIPH = 8,
    parameter int N_IRQ    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_we,
    input  logic [N_PERIPH-1:0] set_mask,
    input  logic                clr_we,
    input  logic [N_PERIPH-1:0] clr_mask,
    input  logic                cpu_idle_req,
    input  logic                cpu_insn_done,
    input  logic [N_IRQ-1:0]    irq_pending,
    input  logic [N_IRQ-1:0]    irq_enable,
    output logic [N_PERIPH-1:0] periph_gclk,
    output logic                cpu_gclk,
    output logic [N_PERIPH-1:0] periph_status,
    output logic [1:0]          cpu_state,
    output logic                cpu_running
);
    logic [N_PERIPH-1:0] en_q;
    cpu_state_e          st_q;
    logic                cpu_en;

    pcm_enable_regs #(.N_PERIPH(N_PERIPH)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .set_we(set_we), .set_mask(set_mask),
        .clr_we(clr_we), .clr_mask(clr_mask),
        .en_q(en_q)
    );

    pcm_cpu_fsm #(.N_IRQ(N_IRQ)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .idle_req(cpu_idle_req), .insn_done(cpu_insn_done),
        .irq_pending(irq_pending), .irq_enable(irq_enable),
        .state_q(st_q), .cpu_clk_en(cpu_en)
    );

    for (genvar g = 0; g < N_PERIPH; g++) begin : g_pgate
        pcm_clk_gate u_gate (.clk(clk), .en(en_q[g]), .gclk(periph_gclk[g]));
    end

    pcm_clk_gate u_cpu_gate (.clk(clk), .en(cpu_en), .gclk(cpu_gclk));

    assign periph_status = en_q;
    assign cpu_state     = st_q;
    assign cpu_running   = cpu_en;

    a_r9_periph_indep: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we && st_q != $past(st_q)) |-> (en_q == $past(en_q)));
endmodule

// File: tb/pwr_clk_gate_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_clk_gate_ctrl_tb;
    localparam int NP = 8;
    localparam int NI = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic set_we = 0, clr_we = 0, idle = 0, done = 0;
    logic [NP-1:0] set_mask = '0, clr_mask = '0;
    logic [NI-1:0] irq_p = '0, irq_e = '0;
    logic [NP-1:0] pg;
    logic cg;
    logic [NP-1:0] pstat;
    logic [1:0] cst;
    logic crun;

    int n_chk = 0, n_fail = 0;
    int cpu_edges = 0;
    int p_edges [NP];

    always #2.5 clk = ~clk;

    pwr_clk_gate_ctrl #(.N_PERIPH(NP), .N_IRQ(NI)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .set_we(set_we), .set_mask(set_mask),
        .clr_we(clr_we), .clr_mask(clr_mask),
        .cpu_idle_req(idle), .cpu_insn_done(done),
        .irq_pending(irq_p), .irq_enable(irq_e),
        .periph_gclk(pg), .cpu_gclk(cg),
        .periph_status(pstat), .cpu_state(cst), .cpu_running(crun)
    );

    always @(posedge cg) cpu_edges++;
    for (genvar g = 0; g < NP; g++) begin : g_cnt
        initial p_edges[g] = 0;
        always @(posedge pg[g]) p_edges[g]++;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr_set(input logic [NP-1:0] m);
        set_we = 1; set_mask = m; step(); set_we = 0; set_mask = '0;
    endtask

    task automatic wr_clr(input logic [NP-1:0] m);
        clr_we = 1; clr_mask = m; step(); clr_we = 0; clr_mask = '0;
    endtask

    task automatic cpu_stop();
        idle = 1; step(); idle = 0;
        done = 1; step(); done = 0;
    endtask

    task automatic cpu_wake();
        irq_p = 4'b0001; irq_e = 4'b0001; step(); irq_p = '0; irq_e = '0;
    endtask

    task automatic t_reset();
        check(pstat == '0, "R1 enables", pstat, 0);
        check(cst == 2'd0, "R1 state", cst, 0);
        check(crun == 1'b1, "R1 running", crun, 1);
    endtask

    task automatic t_set_clear();
        wr_set(8'b0000_0101);
        check(pstat == 8'h05, "R2 set", pstat, 8'h05);
        wr_set(8'b1000_0000);
        check(pstat == 8'h85, "R2 set keeps others", pstat, 8'h85);
        wr_clr(8'b0000_0100);
        check(pstat == 8'h81, "R3 clear", pstat, 8'h81);
        wr_clr(8'b1000_0001);
        check(pstat == 8'h00, "R3 clear all", pstat, 0);
    endtask

    task automatic t_set_clr_same();
        wr_set(8'h02);
        set_we = 1; set_mask = 8'h11; clr_we = 1; clr_mask = 8'h13;
        step();
        set_we = 0; clr_we = 0; set_mask = '0; clr_mask = '0;
        check(pstat == 8'h11, "R4 set wins", pstat, 8'h11);
        wr_clr(8'hFF);
    endtask

    task automatic t_gclk();
        int b0, b1;
        wr_set(8'h01);
        b0 = p_edges[0]; b1 = p_edges[1];
        step(4);
        check(p_edges[0] - b0 == 4, "R8 enabled toggles", p_edges[0] - b0, 4);
        check(p_edges[1] - b1 == 0, "R8 disabled low", p_edges[1] - b1, 0);
        wr_clr(8'h01);
        b0 = p_edges[0];
        step(4);
        check(p_edges[0] - b0 == 0, "R8 stopped after clear", p_edges[0] - b0, 0);
    endtask

    task automatic t_cpu_stop();
        int c0;
        idle = 1; step(); idle = 0;
        check(cst == 2'd1, "R5 pending", cst, 1);
        c0 = cpu_edges;
        step(3);
        check(cpu_edges - c0 == 3, "R5 clock runs while pending", cpu_edges - c0, 3);
        check(cst == 2'd1, "R5 still pending", cst, 1);
        done = 1; step(); done = 0;
        check(cst == 2'd2 && crun == 1'b0, "R5 stopped", cst, 2);
        c0 = cpu_edges;
        step(4);
        check(cpu_edges - c0 == 0, "R5 clock held", cpu_edges - c0, 0);
    endtask

    task automatic t_wake();
        irq_p = 4'b0100; irq_e = 4'b0011;
        step(3);
        check(cst == 2'd2, "R6 masked ignored", cst, 2);
        irq_e = 4'b0100; step();
        irq_p = '0; irq_e = '0;
        check(cst == 2'd0 && crun == 1'b1, "R6 wake", cst, 0);
    endtask

    task automatic t_cancel();
        int c0;
        idle = 1; step(); idle = 0;
        irq_p = 4'b1000; irq_e = 4'b1000; step(); irq_p = '0; irq_e = '0;
        check(cst == 2'd0, "R7 cancel", cst, 0);
        idle = 1; step(); idle = 0;
        done = 1; irq_p = 4'b0010; irq_e = 4'b0010; step();
        done = 0; irq_p = '0; irq_e = '0;
        check(cst == 2'd0, "R7 cancel beats done", cst, 0);
        c0 = cpu_edges;
        step(2);
        check(cpu_edges - c0 == 2, "R7 clock kept running", cpu_edges - c0, 2);
    endtask

    task automatic t_ignore_idle();
        idle = 1; step(); step();
        check(cst == 2'd1, "R10 idle in pending", cst, 1);
        idle = 0; done = 1; step(); done = 0;
        idle = 1; step(); idle = 0;
        check(cst == 2'd2, "R10 idle in stopped", cst, 2);
        cpu_wake();
    endtask

    task automatic t_stopped_writes();
        wr_set(8'h30);
        cpu_stop();
        check(pstat == 8'h30, "R9 enables kept on stop", pstat, 8'h30);
        wr_set(8'h02);
        wr_clr(8'h10);
        check(pstat == 8'h22, "R9 writes while stopped", pstat, 8'h22);
        cpu_wake();
        check(pstat == 8'h22 && cst == 2'd0, "R9 enables kept on wake", pstat, 8'h22);
    endtask

    initial begin
        fork
            begin
                step(2);
                t_reset();
                rst_n = 1'b1;
                step();
                t_reset();
                t_set_clear();
                t_set_clr_same();
                t_gclk();
                t_cpu_stop();
                t_wake();
                t_cancel();
                t_ignore_idle();
                t_stopped_writes();
            end
            begin
                repeat (20000) @(posedge clk);
                check(1'b0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule